// File: doc/BRIEF.md
# Module Configuration Memory Responder

This block is a two-wire bus target that stands in for the small configuration memory carried on a DRAM module. It keeps a 256-byte array that a host controller can read and write over a clock line and a bidirectional data line. The data line is open-drain. Here it is split into a sampled input and an output that, when high, pulls the line low. The block samples both bus lines with its own system clock. It finds START and STOP conditions and bit edges from those samples, so the system clock must run well above the bus bit rate.

The responder answers three 7-bit address groups. In each group the upper four bits are fixed and the lower three bits come from three slot-select pins, so up to eight modules can share one bus. The memory group holds the array and a byte pointer. An alias group reaches the same array, but only while the write-protect input is low. A sensor group returns a 16-bit temperature word. The word is latched from an input port at the moment the address matches.

Top module: `dimm_cfg_responder`

## Requirements
- R1: A 7-bit address whose upper four bits are 4'b1010 and whose lower three bits equal `slot_sel_i` is acknowledged. The same upper bits with any other slot value get no acknowledge (the line reads high).
- R2: Upper address bits 4'b0110 with matching slot bits reach the same array as R1 and are acknowledged only while `wr_protect_i` is low. While it is high, the address is not acknowledged.
- R3: Upper address bits 4'b0011 with matching slot bits are acknowledged for reads only (R/W bit 1). A read returns the `temp_i` value captured at the address match: bits 15:8 first, then bits 7:0, and this pair repeats for further bytes. A write to this group is not acknowledged.
- R4: An address outside all groups gets no acknowledge, and the target leaves the data line released until the next START.
- R5: In a write, the first data byte loads the byte pointer. Each later data byte is stored at the pointer, and the pointer then increments. Every data byte is acknowledged.
- R6: The pointer wraps from 255 to 0, both when writing and when reading.
- R7: While `wr_protect_i` is high, data bytes aimed at locations 0 to 127 are acknowledged but leave the array unchanged. Locations 128 to 255 are still written.
- R8: A repeated START followed by a read address returns bytes starting at the current pointer, advancing one location per byte. After the controller answers a byte with NACK, the target releases the data line.
- R9: After reset, every array location reads 0x00 and the data line is released.
- R10: The target changes its pull-down only while the sampled clock line is low. The one exception is the release forced by a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_pull_o | output | 1 | High pulls the data line low |
| slot_sel_i | input | 3 | Slot identity, used as the low three address bits |
| wr_protect_i | input | 1 | High blocks stores to locations 0..127 and hides the alias group |
| temp_i | input | 16 | Temperature word, latched when a sensor address matches |

## Verification
A wrong address decode shows up within one byte time, as an acknowledge bit of the wrong polarity in the ninth clock of the address byte. A corrupted pointer or a dropped store stays hidden until a later read: the bench reads back every location it writes, including across the 255-to-0 wrap, so the error appears as a wrong data byte some transactions later. A stuck pull-down or a missed NACK release is caught at once, because the bench samples the wire after the controller's NACK and during traffic that is not acknowledged.

// File: rtl/cfg_resp_pkg.sv
package cfg_resp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_WR,
    ST_RD,
    ST_RACK,
    ST_RLOAD,
    ST_SKIP
  } link_st_t;

  typedef enum logic [1:0] {
    GRP_NONE,
    GRP_MEM,
    GRP_ALIAS,
    GRP_TEMP
  } grp_t;

  localparam int unsigned SLOT_W = 3;
  localparam logic [3:0] MEM_HI   = 4'b1010;
  localparam logic [3:0] ALIAS_HI = 4'b0110;
  localparam logic [3:0] TEMP_HI  = 4'b0011;

  // Select the address group for a received 7-bit address and R/W bit.
  function automatic grp_t decode_group(input logic [6:0] a,
                                        input logic [SLOT_W-1:0] slot,
                                        input logic wp,
                                        input logic rd);
    grp_t g;
    g = GRP_NONE;
    if (a[SLOT_W-1:0] == slot) begin
      case (a[6:3])
        MEM_HI:   g = GRP_MEM;
        ALIAS_HI: g = wp ? GRP_NONE : GRP_ALIAS;
        TEMP_HI:  g = rd ? GRP_TEMP : GRP_NONE;
        default:  g = GRP_NONE;
      endcase
    end
    return g;
  endfunction

endpackage

// File: rtl/bus_edge_sense.sv
module bus_edge_sense #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [SYNC_STAGES-1:0] scl_sync;
  logic [SYNC_STAGES-1:0] sda_sync;
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
    end
  end

  assign scl_s    = scl_sync[SYNC_STAGES-1];
  assign sda_s    = sda_sync[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/cfg_link_fsm.sv
module cfg_link_fsm
  import cfg_resp_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned TW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic              wp,
  input  logic [TW-1:0]     temp_val,
  input  logic [DW-1:0]     mem_rdata,
  output logic              sda_drv,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DW-1:0]     mem_wdata,
  output logic [AW-1:0]     ptr,
  output logic              link_skip
);

  localparam int unsigned CW         = $clog2(DW) + 1;
  localparam int unsigned TEMP_BYTES = TW / DW;
  localparam int unsigned TSW        = (TEMP_BYTES > 1) ? $clog2(TEMP_BYTES) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);
  localparam logic [CW-1:0] ALL_BITS = CW'(DW);

  // Lower half of the array is the protected region.
  function automatic logic store_blocked(input logic prot, input logic [AW-1:0] p);
    return prot && !p[AW-1];
  endfunction

  // Byte idx of the captured word, most significant first.
  function automatic logic [DW-1:0] temp_pick(input logic [TW-1:0] cap,
                                              input logic [TSW-1:0] idx);
    logic [TW-1:0] sh;
    sh = cap >> (DW * (TEMP_BYTES - 1 - int'(idx)));
    return sh[DW-1:0];
  endfunction

  link_st_t      st;
  grp_t          grp;
  logic [DW-1:0] shreg;
  logic [DW-1:0] txreg;
  logic [CW-1:0] bitcnt;
  logic          rd_mode;
  logic          ptr_pending;
  logic          ack_half;
  logic [TSW-1:0] tsel;
  logic [TW-1:0] temp_cap;

  logic [DW-1:0] rx_next;
  grp_t          hit;
  logic [DW-1:0] next_tx;
  logic [TSW-1:0] tsel_next;

  assign rx_next   = {shreg[DW-2:0], sda_s};
  assign hit       = decode_group(rx_next[7:1], slot_sel, wp, rx_next[0]);
  assign next_tx   = (grp == GRP_TEMP) ? temp_pick(temp_cap, tsel) : mem_rdata;
  assign tsel_next = (tsel == TSW'(TEMP_BYTES - 1)) ? '0 : tsel + 1'b1;
  assign link_skip = (st == ST_SKIP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      grp         <= GRP_NONE;
      shreg       <= '0;
      txreg       <= '0;
      bitcnt      <= '0;
      rd_mode     <= 1'b0;
      ptr_pending <= 1'b0;
      ack_half    <= 1'b0;
      tsel        <= '0;
      temp_cap    <= '0;
      ptr         <= '0;
      sda_drv     <= 1'b0;
      mem_we      <= 1'b0;
      mem_waddr   <= '0;
      mem_wdata   <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_ev) begin
        st       <= ST_ADDR;
        bitcnt   <= '0;
        ack_half <= 1'b0;
        sda_drv  <= 1'b0;
      end else if (stop_ev) begin
        st      <= ST_IDLE;
        sda_drv <= 1'b0;
      end else begin
        case (st)
          ST_ADDR: if (scl_rise) begin
            shreg  <= rx_next;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              if (hit != GRP_NONE) begin
                st          <= ST_ACK;
                grp         <= hit;
                rd_mode     <= rx_next[0];
                ptr_pending <= !rx_next[0];
                tsel        <= '0;
                temp_cap    <= temp_val;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_ACK: if (scl_fall) begin
            if (!ack_half) begin
              ack_half <= 1'b1;
              sda_drv  <= 1'b1;
            end else begin
              ack_half <= 1'b0;
              if (rd_mode) begin
                txreg   <= next_tx;
                sda_drv <= !next_tx[DW-1];
                bitcnt  <= CW'(1);
                st      <= ST_RD;
              end else begin
                sda_drv <= 1'b0;
                bitcnt  <= '0;
                st      <= ST_WR;
              end
            end
          end
          ST_WR: if (scl_rise) begin
            shreg  <= rx_next;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) begin
              bitcnt <= '0;
              st     <= ST_ACK;
              if (ptr_pending) begin
                ptr         <= rx_next[AW-1:0];
                ptr_pending <= 1'b0;
              end else begin
                mem_we    <= !store_blocked(wp, ptr);
                mem_waddr <= ptr;
                mem_wdata <= rx_next;
                ptr       <= ptr + 1'b1;
              end
            end
          end
          ST_RD: if (scl_fall) begin
            if (bitcnt == ALL_BITS) begin
              sda_drv <= 1'b0;
              st      <= ST_RACK;
            end else begin
              sda_drv <= !txreg[DW-2];
              txreg   <= {txreg[DW-2:0], 1'b0};
              bitcnt  <= bitcnt + 1'b1;
            end
          end
          ST_RACK: if (scl_rise) begin
            if (grp == GRP_TEMP) tsel <= tsel_next;
            else                 ptr  <= ptr + 1'b1;
            st <= sda_s ? ST_SKIP : ST_RLOAD;
          end
          ST_RLOAD: if (scl_fall) begin
            txreg   <= next_tx;
            sda_drv <= !next_tx[DW-1];
            bitcnt  <= CW'(1);
            st      <= ST_RD;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dimm_cfg_responder.sv
module dimm_cfg_responder
  import cfg_resp_pkg::*;
#(
  parameter int unsigned AW          = 8,
  parameter int unsigned TEMP_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [SLOT_W-1:0] slot_sel_i,
  input  logic              wr_protect_i,
  input  logic [TEMP_W-1:0] temp_i
);

  localparam int unsigned DW = 8;

  logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic          mem_we, link_skip;
  logic [AW-1:0] mem_waddr, ptr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  bus_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  cfg_link_fsm #(.AW(AW), .DW(DW), .TW(TEMP_W)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_ev  (start_ev),
    .stop_ev   (stop_ev),
    .sda_s     (sda_s),
    .slot_sel  (slot_sel_i),
    .wp        (wr_protect_i),
    .temp_val  (temp_i),
    .mem_rdata (mem_rdata),
    .sda_drv   (sda_pull_o),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .ptr       (ptr),
    .link_skip (link_skip)
  );

  cfg_store #(.AW(AW), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (ptr),
    .rdata (mem_rdata)
  );

endmodule

// File: rtl/dimm_cfg_responder_chk.sv
module dimm_cfg_responder_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          start_ev,
  input logic          stop_ev,
  input logic          sda_pull_o,
  input logic          wr_protect_i,
  input logic          link_skip,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic [AW-1:0] ptr
);

  // R7: no store lands in the protected half while protection was high
  assert_no_protected_store_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !($past(wr_protect_i) && !mem_waddr[AW-1]));

  // R5, R6: every store leaves the pointer one past the stored location, modulo depth
  assert_ptr_follows_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (ptr == AW'(mem_waddr + 1'b1)));

  // R4: while ignoring traffic the line is never pulled
  assert_skip_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
    link_skip |-> !sda_pull_o);

  // R10: a START always releases the line in the next cycle
  assert_start_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_pull_o);

  // R10: pull-down only moves while the sampled clock was low, or on START/STOP
  assert_change_on_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> ($past(!scl_s) || $past(start_ev) || $past(stop_ev)));

endmodule

bind dimm_cfg_responder dimm_cfg_responder_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_s        (scl_s),
  .start_ev     (start_ev),
  .stop_ev      (stop_ev),
  .sda_pull_o   (sda_pull_o),
  .wr_protect_i (wr_protect_i),
  .link_skip    (link_skip),
  .mem_we       (mem_we),
  .mem_waddr    (mem_waddr),
  .ptr          (ptr)
);

// File: tb/dimm_cfg_responder_tb.sv
module dimm_cfg_responder_tb;

  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tb_scl = 1'b1;
  logic tb_pull = 1'b0;
  logic [2:0] slot = 3'b101;
  logic wp = 1'b0;
  logic [15:0] temp = 16'h1A2B;
  logic sda_pull;
  logic sda_bus;

  assign sda_bus = !(sda_pull | tb_pull);

  always #5 clk = ~clk;

  dimm_cfg_responder u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (tb_scl),
    .sda_i        (sda_bus),
    .sda_pull_o   (sda_pull),
    .slot_sel_i   (slot),
    .wr_protect_i (wp),
    .temp_i       (temp)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_val;
  event       obs_e;

  task automatic push(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic observe(input logic [7:0] v);
    obs_val = v;
    ->obs_e;
  endtask

  // Scoreboard monitor: pops one expectation per observed bus result.
  initial forever begin
    @(obs_e);
    n_chk++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL scoreboard empty: actual %h expected none", obs_val);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (obs_val !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, obs_val, e);
      end
    end
  end

  task automatic direct_check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (tb_scl == 1'b0) begin
      tb_pull = 1'b0; waitc(H);
      tb_scl = 1'b1;  waitc(H);
    end
    tb_pull = 1'b1; waitc(H);
    tb_scl = 1'b0;  waitc(H);
  endtask

  task automatic bus_stop();
    tb_pull = 1'b1; waitc(H);
    tb_scl = 1'b1;  waitc(H);
    tb_pull = 1'b0; waitc(H);
  endtask

  // Sends a byte; the ninth-bit line level goes to the scoreboard (0 = ACK).
  task automatic wbyte(input logic [7:0] b);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      tb_pull = !b[i]; waitc(H);
      tb_scl = 1'b1;   waitc(H);
      tb_scl = 1'b0;
    end
    tb_pull = 1'b0; waitc(H);
    tb_scl = 1'b1;  waitc(H/2);
    a = sda_bus;    waitc(H/2);
    tb_scl = 1'b0;
    observe({7'd0, a});
  endtask

  task automatic rbyte(input logic nack);
    logic [7:0] b;
    tb_pull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitc(H);
      tb_scl = 1'b1; waitc(H/2);
      b[i] = sda_bus; waitc(H/2);
      tb_scl = 1'b0;
    end
    tb_pull = !nack; waitc(H);
    tb_scl = 1'b1;   waitc(H);
    tb_scl = 1'b0;
    tb_pull = 1'b0;
    observe(b);
  endtask

  // Address byte with expected ACK (0) or NACK (1).
  task automatic addr(input logic [6:0] a, input logic rd, input logic nak, input string tag);
    push({7'd0, nak}, tag);
    wbyte({a, rd});
  endtask

  task automatic data_w(input logic [7:0] d, input string tag);
    push(8'h00, tag);
    wbyte(d);
  endtask

  task automatic data_r(input logic [7:0] d, input logic nack, input string tag);
    push(d, tag);
    rbyte(nack);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    direct_check(sda_pull, 1'b0, "R9 released after reset");

    // R9: untouched location reads zero
    bus_start(); addr(7'h55, 0, 0, "R1"); data_w(8'h20, "R5");
    bus_start(); addr(7'h55, 1, 0, "R8"); data_r(8'h00, 1, "R9"); bus_stop();

    // R5: pointer then three stored bytes
    bus_start(); addr(7'h55, 0, 0, "R1");
    data_w(8'h10, "R5"); data_w(8'hA1, "R5"); data_w(8'hA2, "R5"); data_w(8'hA3, "R5");
    bus_stop();

    // R8: repeated START read from pointer, release after NACK
    bus_start(); addr(7'h55, 0, 0, "R8"); data_w(8'h10, "R8");
    bus_start(); addr(7'h55, 1, 0, "R8");
    data_r(8'hA1, 0, "R8"); data_r(8'hA2, 0, "R8"); data_r(8'hA3, 1, "R8");
    waitc(H);
    direct_check(sda_pull, 1'b0, "R8 released after NACK");
    bus_stop();

    // R1: other slots in the memory group are not acknowledged
    bus_start(); addr(7'h51, 0, 1, "R1"); bus_stop();
    bus_start(); addr(7'h57, 1, 1, "R1"); bus_stop();

    // R4: foreign address, line stays released for following byte
    bus_start(); addr(7'h42, 1, 1, "R4");
    data_r(8'hFF, 1, "R4");
    direct_check(sda_pull, 1'b0, "R4 idle after foreign address");
    bus_stop();

    // R6: wrap on write and on read
    bus_start(); addr(7'h55, 0, 0, "R6");
    data_w(8'hFF, "R6"); data_w(8'h5A, "R6"); data_w(8'h6B, "R6");
    bus_stop();
    bus_start(); addr(7'h55, 0, 0, "R6"); data_w(8'hFF, "R6");
    bus_start(); addr(7'h55, 1, 0, "R6");
    data_r(8'h5A, 0, "R6"); data_r(8'h6B, 0, "R6"); data_r(8'h00, 1, "R6");
    bus_stop();

    // R2: alias group reaches the same array while unprotected
    bus_start(); addr(7'h35, 0, 0, "R2"); data_w(8'h10, "R2");
    bus_start(); addr(7'h35, 1, 0, "R2"); data_r(8'hA1, 1, "R2");
    bus_stop();

    // R7: protected writes acknowledged; low half kept, high half stored
    wp = 1'b1;
    bus_start(); addr(7'h35, 0, 1, "R2"); bus_stop();
    bus_start(); addr(7'h55, 0, 0, "R7"); data_w(8'h10, "R7"); data_w(8'hEE, "R7"); bus_stop();
    bus_start(); addr(7'h55, 0, 0, "R7"); data_w(8'h90, "R7"); data_w(8'h77, "R7"); bus_stop();
    bus_start(); addr(7'h55, 0, 0, "R7"); data_w(8'h10, "R7");
    bus_start(); addr(7'h55, 1, 0, "R7"); data_r(8'hA1, 1, "R7"); bus_stop();
    bus_start(); addr(7'h55, 0, 0, "R7"); data_w(8'h90, "R7");
    bus_start(); addr(7'h55, 1, 0, "R7"); data_r(8'h77, 1, "R7"); bus_stop();
    wp = 1'b0;

    // R3: sensor word captured at match, high byte first, repeating
    bus_start(); addr(7'h1D, 1, 0, "R3");
    temp = 16'h3344;
    data_r(8'h1A, 0, "R3"); data_r(8'h2B, 0, "R3"); data_r(8'h1A, 1, "R3");
    bus_stop();
    bus_start(); addr(7'h1D, 0, 1, "R3"); bus_stop();
    bus_start(); addr(7'h1D, 1, 0, "R3");
    data_r(8'h33, 0, "R3"); data_r(8'h44, 1, "R3");
    bus_stop();

    waitc(20);
    done = 1;
    finish_run();
  end

endmodule